// File: doc/BRIEF.md
# I2C Register Access Slave

This block lets an I2C host read and write a 256-entry byte register file that sits beside it. It samples the bus lines SCL and SDA with a fast system clock, finds start and stop conditions, and frames each byte as eight data bits followed by one acknowledge clock. The first byte after a start carries a 7-bit device address and a direction bit. A strap input sets the low address bit, so two of these blocks can share one bus.

A write sends a subaddress byte and then any number of data bytes. Each data byte produces a one-cycle write strobe to the register file, and the pointer then advances. A read returns bytes from the pointer onward, MSB first. A read that follows a repeated start after a subaddress write continues at the written subaddress. A read that arrives with no subaddress written since the last stop starts at the fixed subaddress 0x08. This short form lets a host poll a status block without sending a subaddress. SDA is driven only as an open-drain output enable.

Top module: `i2c_reg_slave`

## Requirements
- R1: A start (SDA falling while SCL is high) begins device-address decoding from any state. A stop (SDA rising while SCL is high) returns the block to idle with SDA released.
- R2: The device address matches when the 7-bit address equals {6'b011101, addr_sel_i}, that is, full bytes 0x74/0x75 with the strap low and 0x76/0x77 with the strap high. On a match the block pulls SDA low in the 9th clock. With no match it never drives SDA and makes no register writes until the next start.
- R3: In a write, the block acknowledges the subaddress byte and every data byte in the 9th clock. Each data byte gives a one-cycle reg_we_o pulse, with reg_addr_o equal to the current pointer and reg_wdata_o equal to the received byte.
- R4: The pointer increases by one after every data byte, both read and write, and wraps from 0xFF to 0x00.
- R5: A read issued after a repeated start that follows a subaddress write begins at that subaddress.
- R6: A read issued with no subaddress written since the last stop or reset begins at subaddress 0x08.
- R7: Read bytes go out MSB first. SDA output changes only while SCL is low, except when a start or stop forces a release.
- R8: If the host leaves SDA high in the acknowledge clock of a read byte, the block stops driving SDA and ignores further clocks until a start or stop.
- R9: A start in the middle of a byte throws away the partial byte and restarts framing, so the next full byte is decoded as a device address.
- R10: After reset, sda_oe_o and reg_we_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_sel_i | input | 1 | Strap that sets the low device-address bit |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | High to pull SDA low |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_addr_o | output | 8 | Register pointer, used for both reads and writes |
| reg_wdata_o | output | 8 | Byte to be written |
| reg_rdata_i | input | 8 | Register contents at reg_addr_o |

## Verification
The hardest cases to reach from the ports are those where bus history, not the current byte, decides the outcome. One is whether a read starts at 0x08 or at the written subaddress, which depends on whether a stop came between the subaddress write and the read. Another is the released state after a host not-acknowledge, which can only be seen by clocking a further byte before the stop. The stimulus therefore covers both orderings: subaddress, repeated start, then read; and subaddress, stop, then read. It also clocks a full extra byte after a not-acknowledge and expects all ones. A repeated start is placed three bits into a byte, and writes across 0xFF are made with each strap setting. A bench model keeps the expected register contents and write order, and checks every clock that SDA is not driven to change while SCL is high.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_SUB,
    ST_WR,
    ST_RD
  } i2c_state_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic              scl_p, sda_p;
  logic              scl_s, sda_s;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_sr <= '1;
          sda_sr <= '1;
        end else begin
          scl_sr <= scl_i;
          sda_sr <= sda_i;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_sr <= '1;
          sda_sr <= '1;
        end else begin
          scl_sr <= {scl_sr[STAGES-2:0], scl_i};
          sda_sr <= {sda_sr[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_sr[STAGES-1];
  assign sda_s = sda_sr[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;

  assert_edges_exclusive_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o || stop_o) |-> !(scl_rise_o || scl_fall_o));
endmodule

// File: rtl/i2c_reg_fsm.sv
module i2c_reg_fsm
  import i2c_reg_pkg::*;
#(
  parameter logic [5:0]        DEV_ADDR_HI  = 6'b011101,
  parameter logic [BYTE_W-1:0] IMPLICIT_SUB = 8'h08
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_sel_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] reg_rdata_i,
  output logic              sda_oe_o,
  output logic              reg_we_o,
  output logic [BYTE_W-1:0] reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o
);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  i2c_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-2:0] shift_q;
  logic [BYTE_W-1:0] ptr_q, tx_q, wdata_q;
  logic              ack_q, rw_q, sub_seen_q, sda_oe_q, reg_we_q;
  logic [BYTE_W-1:0] rx_byte;
  logic [2:0]        tx_idx;

  assign rx_byte = {shift_q, sda_i};
  assign tx_idx  = 3'(LAST_BIT - cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      shift_q    <= '0;
      ptr_q      <= '0;
      tx_q       <= '0;
      wdata_q    <= '0;
      ack_q      <= 1'b0;
      rw_q       <= 1'b0;
      sub_seen_q <= 1'b0;
      sda_oe_q   <= 1'b0;
      reg_we_q   <= 1'b0;
    end else begin
      reg_we_q <= 1'b0;
      if (start_i) begin
        state_q  <= ST_DEV;
        cnt_q    <= '0;
        ack_q    <= 1'b0;
        sda_oe_q <= 1'b0;
      end else if (stop_i) begin
        state_q    <= ST_IDLE;
        cnt_q      <= '0;
        ack_q      <= 1'b0;
        sda_oe_q   <= 1'b0;
        sub_seen_q <= 1'b0;
      end else if (state_q != ST_IDLE) begin
        if (scl_rise_i) begin
          if (cnt_q != ACK_SLOT) begin
            shift_q <= rx_byte[BYTE_W-2:0];
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              unique case (state_q)
                ST_DEV: begin
                  ack_q <= (rx_byte[BYTE_W-1:1] == {DEV_ADDR_HI, addr_sel_i});
                  rw_q  <= rx_byte[0];
                end
                ST_SUB: begin
                  ptr_q      <= rx_byte;
                  sub_seen_q <= 1'b1;
                  ack_q      <= 1'b1;
                end
                ST_WR: begin
                  reg_we_q <= 1'b1;
                  wdata_q  <= rx_byte;
                  ack_q    <= 1'b1;
                end
                default: ack_q <= 1'b0;
              endcase
            end
          end else begin
            cnt_q <= '0;
            unique case (state_q)
              ST_DEV: begin
                if (!ack_q) state_q <= ST_IDLE;
                else if (rw_q) begin
                  state_q <= ST_RD;
                  if (!sub_seen_q) ptr_q <= IMPLICIT_SUB;
                end else state_q <= ST_SUB;
              end
              ST_SUB: state_q <= ST_WR;
              ST_WR:  ptr_q <= ptr_q + 1'b1;
              default: begin
                ptr_q <= ptr_q + 1'b1;
                if (sda_i) state_q <= ST_IDLE;  // host not-acknowledge
              end
            endcase
          end
        end
        if (scl_fall_i) begin
          if (cnt_q == ACK_SLOT) sda_oe_q <= ack_q;
          else if (state_q == ST_RD) begin
            if (cnt_q == '0) begin
              tx_q     <= reg_rdata_i;
              sda_oe_q <= ~reg_rdata_i[BYTE_W-1];
            end else sda_oe_q <= ~tx_q[tx_idx];
          end else sda_oe_q <= 1'b0;
        end
      end
    end
  end

  assign sda_oe_o    = sda_oe_q;
  assign reg_we_o    = reg_we_q;
  assign reg_addr_o  = ptr_q;
  assign reg_wdata_o = wdata_q;

  assert_release_after_stop_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_q);
  assert_we_in_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_q |-> (state_q == ST_WR));
  assert_ptr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WR && scl_rise_i && cnt_q == ACK_SLOT && !start_i && !stop_i)
    |=> ptr_q == $past(ptr_q) + 1'b1);
  assert_oe_on_edges_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_q) |-> $past(scl_fall_i || start_i || stop_i));
  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sda_oe_q);
  assert_start_reframes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == ST_DEV && cnt_q == '0));
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_reg_pkg::*;
#(
  parameter int                SYNC_STAGES  = 2,
  parameter logic [5:0]        DEV_ADDR_HI  = 6'b011101,
  parameter logic [BYTE_W-1:0] IMPLICIT_SUB = 8'h08
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_sel_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              reg_we_o,
  output logic [BYTE_W-1:0] reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  i2c_reg_fsm #(
    .DEV_ADDR_HI  (DEV_ADDR_HI),
    .IMPLICIT_SUB (IMPLICIT_SUB)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_sel_i  (addr_sel_i),
    .sda_i       (sda_s),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_ev),
    .stop_i      (stop_ev),
    .reg_rdata_i (reg_rdata_i),
    .sda_oe_o    (sda_oe_o),
    .reg_we_o    (reg_we_o),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o)
  );
endmodule

// File: tb/i2c_reg_slave_tb.sv
module i2c_reg_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_bus;
  logic sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [15:0] wr_exp_q [$];
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic prev_scl = 1'b1;
  logic prev_oe = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  i2c_reg_slave u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .addr_sel_i  (strap),
    .scl_i       (m_scl),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe),
    .reg_we_o    (reg_we),
    .reg_addr_o  (reg_addr),
    .reg_wdata_o (reg_wdata),
    .reg_rdata_i (reg_rdata)
  );

  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock model: write order and SDA stability while SCL high
  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_we) begin
        if (wr_exp_q.size() == 0) chk(1'b0, "R3 unexpected write", {reg_addr, reg_wdata}, 0);
        else begin
          logic [15:0] e;
          e = wr_exp_q.pop_front();
          chk({reg_addr, reg_wdata} == e, "R3 write addr/data", {reg_addr, reg_wdata}, e);
        end
      end
      if (m_scl && prev_scl) chk(sda_oe == prev_oe, "R7 sda stable in scl high", sda_oe, prev_oe);
    end
    prev_scl = m_scl;
    prev_oe  = sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_c();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q); m_scl = 1'b0;
  endtask

  task automatic stop_c();
    tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    tick(Q); m_sda = b; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    tick(Q); m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); b = sda_bus; tick(Q); m_scl = 1'b0;
  endtask

  task automatic wb(input logic [7:0] d, input logic exp_ack, input string req);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    chk(a == ~exp_ack, req, a, ~exp_ack);
  endtask

  task automatic rb(input logic nack, input logic [7:0] exp, input string req);
    logic [7:0] d;
    for (int i = 7; i >= 0; i--) begin
      logic b;
      get_bit(b);
      d[i] = b;
    end
    put_bit(nack);
    chk(d == exp, req, d, exp);
  endtask

  task automatic exp_wr(input logic [7:0] a, input logic [7:0] d);
    wr_exp_q.push_back({a, d});
    exp_mem[a] = d;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]     = 8'(i) ^ 8'h5A;
      exp_mem[i] = 8'(i) ^ 8'h5A;
    end
    tick(4);
    chk(sda_oe == 1'b0, "R10 reset sda_oe", sda_oe, 0);
    chk(reg_we == 1'b0, "R10 reset reg_we", reg_we, 0);
    rst_n = 1'b1;
    tick(4);

    // R3 R4 write burst, strap low
    start_c();
    wb(8'h74, 1, "R2 addr ack 0x74");
    wb(8'h10, 1, "R3 sub ack");
    exp_wr(8'h10, 8'hA5); wb(8'hA5, 1, "R3 data ack");
    exp_wr(8'h11, 8'h3C); wb(8'h3C, 1, "R4 data ack incr");
    stop_c();

    // R5 read after repeated start, R7 msb first
    start_c();
    wb(8'h74, 1, "R2 addr ack");
    wb(8'h10, 1, "R3 sub ack");
    start_c();
    wb(8'h75, 1, "R5 read addr ack");
    rb(0, exp_mem[8'h10], "R5 read at written sub");
    rb(0, exp_mem[8'h11], "R4 read incr");
    rb(1, exp_mem[8'h12], "R4 read incr 2");
    stop_c();

    // R6 short read
    start_c();
    wb(8'h75, 1, "R6 addr ack");
    rb(0, exp_mem[8'h08], "R6 implicit 0x08");
    rb(1, exp_mem[8'h09], "R6 implicit next");
    stop_c();

    // R2 mismatches with strap low
    start_c();
    wb(8'h76, 0, "R2 no ack 0x76 strap low");
    wb(8'h55, 0, "R2 ignored data");
    stop_c();
    start_c();
    wb(8'h77, 0, "R2 no ack 0x77 strap low");
    rb(1, 8'hFF, "R2 bus released");
    stop_c();

    // strap high, wrap across 0xFF
    strap = 1'b1;
    start_c();
    wb(8'h76, 1, "R2 ack 0x76 strap high");
    wb(8'hFF, 1, "R3 sub ack");
    exp_wr(8'hFF, 8'h11); wb(8'h11, 1, "R3 data ack");
    exp_wr(8'h00, 8'h22); wb(8'h22, 1, "R4 wrap write");
    stop_c();
    start_c();
    wb(8'h74, 0, "R2 no ack 0x74 strap high");
    stop_c();
    start_c();
    wb(8'h76, 1, "R2 addr ack");
    wb(8'hFF, 1, "R3 sub ack");
    start_c();
    wb(8'h77, 1, "R5 read addr ack");
    rb(0, exp_mem[8'hFF], "R5 read at 0xFF");
    rb(1, exp_mem[8'h00], "R4 read wrap");
    stop_c();

    // R8 nack then released
    start_c();
    wb(8'h77, 1, "R6 addr ack");
    rb(1, exp_mem[8'h08], "R6 implicit 0x08");
    rb(1, 8'hFF, "R8 released after nack");
    stop_c();

    // R9 start mid-byte
    start_c();
    put_bit(1); put_bit(0); put_bit(1);
    start_c();
    wb(8'h76, 1, "R9 addr after abort");
    wb(8'h20, 1, "R9 sub ack");
    exp_wr(8'h20, 8'h99); wb(8'h99, 1, "R9 data ack");
    stop_c();

    // R6 stop forgets subaddress
    start_c();
    wb(8'h76, 1, "R6 addr ack");
    wb(8'h30, 1, "R6 sub ack");
    stop_c();
    start_c();
    wb(8'h77, 1, "R6 addr ack");
    rb(1, exp_mem[8'h08], "R6 stop clears sub");
    stop_c();

    tick(10);
    chk(wr_exp_q.size() == 0, "R3 missing writes", wr_exp_q.size(), 0);
    chk(sda_oe == 1'b0, "R1 idle after stop", sda_oe, 0);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule